// File: doc/BRIEF.md
# Flash Status Register Unit

This block holds the status byte of a banked parallel flash memory and drives it onto the read data path. A program/erase engine outside the block reports its progress through single-cycle event inputs: start of an operation with the bank it occupies, completion, erase or program suspension, resumption, and four kinds of failure. The block folds these into one status byte. Ready and suspend state follow the engine without any command. Failure flags stay set until software clears them.

Bus commands choose whether reads return the status byte or the array data. The same command input carries the start of a program or erase. That start is refused while any failure flag is set. Chip-enable and output-enable arrive asynchronously and pass through a synchronizer. On the cycle the combined enable becomes active, the block captures a snapshot of the status byte. It holds that snapshot on the data output until the enable is released. Bit 0 depends on the ready bit and on the bank addressed by the read. When the buffered factory-program mode input is high, bit 0 instead reports whether the engine can take the next buffer load.

Top module: `flash_status_unit`

## Requirements
- R1: After reset the status byte is 8'h80, reads return array data, `data_o` is 0, and `eng_start_o`, `cmd_rej_o` and `proto_err_o` are low.
- R2: Bit 7 goes to 0 on `ev_busy_i` (which also records `ev_bank_i` as the active bank) and on `ev_resume_i`. It goes to 1 on `ev_done_i` and on either suspend event. The precedence is done, then erase suspend, then program suspend, then resume, then busy.
- R3: `ev_esusp_i` sets bit 6 and `ev_psusp_i` sets bit 2. Both bits return to 0 on `ev_resume_i` or `ev_done_i`.
- R4: The failure flags are bit 5 (erase or blank check, `fail_erase_i`), bit 4 (program, `fail_prog_i`), bit 3 (programming voltage, `fail_vpp_i`) and bit 1 (protected block, `fail_prot_i`). Once set, a flag stays set until a clear-status command (`cmd_i` = 2).
- R5: A failure input is recorded only while bit 7 is 0. A failure that arrives in the same cycle as a clear-status command is kept.
- R6: With the buffered mode input low, bit 0 is 1 when bit 7 is 0 and `addr_bank_i` differs from the active bank. In every other case it is 0.
- R7: With `fbuf_mode_i` high, bit 0 is the inverse of `fbuf_rdy_i` while bit 7 is 0, and 0 while bit 7 is 1.
- R8: The status byte is captured SYNC_STAGES+1 clock edges after chip-enable and output-enable are both low. It stays on `data_o` unchanged until they are released, whatever events occur in the meantime.
- R9: `cmd_i` = 1 (read status) and an accepted start select the status view. `cmd_i` = 3 (read array) selects `array_data_i`. The view is latched at capture. `data_o` is 0 whenever no read is active.
- R10: A read captured in the status view with `burst_i` high raises `proto_err_o` for one cycle and still returns the same latched byte.
- R11: A start command (`cmd_i` = 4) pulses `eng_start_o` one cycle later if no failure flag is set. Otherwise it pulses `cmd_rej_o`, and `eng_start_o` stays low. Other `cmd_i` codes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_i | input | 3 | Bus command: 0 none, 1 read status, 2 clear status, 3 read array, 4 start program/erase |
| ev_busy_i | input | 1 | Engine began an operation |
| ev_done_i | input | 1 | Engine finished its operation |
| ev_esusp_i | input | 1 | Erase suspended |
| ev_psusp_i | input | 1 | Program suspended |
| ev_resume_i | input | 1 | Suspended operation resumed |
| ev_bank_i | input | BANK_W | Bank of the operation starting with ev_busy_i |
| fail_erase_i | input | 1 | Erase or blank-check failure |
| fail_prog_i | input | 1 | Program failure |
| fail_vpp_i | input | 1 | Programming voltage out of range |
| fail_prot_i | input | 1 | Write to protected block |
| fbuf_mode_i | input | 1 | Buffered factory-program mode active |
| fbuf_rdy_i | input | 1 | Engine ready for next buffer load |
| ce_ni | input | 1 | Chip enable, active low, asynchronous |
| oe_ni | input | 1 | Output enable, active low, asynchronous |
| burst_i | input | 1 | Current read is a burst read |
| addr_bank_i | input | BANK_W | Bank addressed by the read |
| array_data_i | input | 8 | Array data for the array view |
| data_o | output | 8 | Read data |
| proto_err_o | output | 1 | Burst read of status, one-cycle pulse |
| eng_start_o | output | 1 | Start pulse to the engine |
| cmd_rej_o | output | 1 | Start refused, one-cycle pulse |

## Verification
On every cycle, the assertions check the following. Failure flags survive until a clear. A flag appears only while the engine is busy, and one that arrives together with a clear wins over it. A start with flags set is refused. Bit 0 never reads 1 alongside ready. The held output does not move while a status read is active, and the output is zero outside a read. The bench scenarios are the only place to see the bit positions of each flag, the bank comparison, the buffered-mode meaning of bit 0, the synchronizer latency to capture, and the burst error pulse. Each of these needs an expected byte built from the order of past events.

// File: rtl/fsu_pkg.sv
package fsu_pkg;
  localparam int unsigned STAT_W = 8;

  typedef enum logic [2:0] {
    CMD_NONE     = 3'd0,
    CMD_RD_STAT  = 3'd1,
    CMD_CLR_STAT = 3'd2,
    CMD_RD_ARRAY = 3'd3,
    CMD_START_PE = 3'd4
  } cmd_e;

  typedef enum logic {
    VIEW_ARRAY  = 1'b0,
    VIEW_STATUS = 1'b1
  } view_e;

  typedef struct packed {
    logic erase;
    logic prog;
    logic vpp;
    logic prot;
  } fail_t;

  function automatic logic [STAT_W-1:0] pack_status(
    input logic  ready,
    input logic  esusp,
    input logic  psusp,
    input fail_t fl,
    input logic  bit0
  );
    return {ready, esusp, fl.erase, fl.prog, fl.vpp, psusp, fl.prot, bit0};
  endfunction
endpackage

// File: rtl/fsu_sync.sv
module fsu_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= RST_VAL;
        else         chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/fsu_status_core.sv
module fsu_status_core
  import fsu_pkg::*;
#(
  parameter int unsigned BANK_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        cmd_i,
  input  logic              ev_busy_i,
  input  logic              ev_done_i,
  input  logic              ev_esusp_i,
  input  logic              ev_psusp_i,
  input  logic              ev_resume_i,
  input  logic [BANK_W-1:0] ev_bank_i,
  input  fail_t             fail_i,
  input  logic              fbuf_mode_i,
  input  logic              fbuf_rdy_i,
  input  logic [BANK_W-1:0] addr_bank_i,
  output logic [STAT_W-1:0] status_o,
  output view_e             view_o,
  output logic              eng_start_o,
  output logic              cmd_rej_o
);
  logic              ready_q, esusp_q, psusp_q;
  fail_t             fail_q, fail_d;
  logic [BANK_W-1:0] bank_q;
  view_e             view_q;
  logic              rd_stat, clr_stat, rd_arr, start_cmd, any_fail, bit0;

  assign rd_stat   = (cmd_i == CMD_RD_STAT);
  assign clr_stat  = (cmd_i == CMD_CLR_STAT);
  assign rd_arr    = (cmd_i == CMD_RD_ARRAY);
  assign start_cmd = (cmd_i == CMD_START_PE);
  assign any_fail  = |fail_q;

  // engine state, fixed precedence
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q <= 1'b1;
      esusp_q <= 1'b0;
      psusp_q <= 1'b0;
      bank_q  <= '0;
    end else if (ev_done_i) begin
      ready_q <= 1'b1;
      esusp_q <= 1'b0;
      psusp_q <= 1'b0;
    end else if (ev_esusp_i) begin
      ready_q <= 1'b1;
      esusp_q <= 1'b1;
    end else if (ev_psusp_i) begin
      ready_q <= 1'b1;
      psusp_q <= 1'b1;
    end else if (ev_resume_i) begin
      ready_q <= 1'b0;
      esusp_q <= 1'b0;
      psusp_q <= 1'b0;
    end else if (ev_busy_i) begin
      ready_q <= 1'b0;
      bank_q  <= ev_bank_i;
    end
  end

  // sticky flags: new failures only while busy, set beats clear
  always_comb begin
    fail_d = clr_stat ? fail_t'('0) : fail_q;
    if (!ready_q) fail_d = fail_d | fail_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fail_q <= '0;
    else         fail_q <= fail_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      view_q      <= VIEW_ARRAY;
      eng_start_o <= 1'b0;
      cmd_rej_o   <= 1'b0;
    end else begin
      eng_start_o <= start_cmd && !any_fail;
      cmd_rej_o   <= start_cmd && any_fail;
      if (rd_stat || (start_cmd && !any_fail)) view_q <= VIEW_STATUS;
      else if (rd_arr)                         view_q <= VIEW_ARRAY;
    end
  end

  always_comb begin
    if (ready_q)          bit0 = 1'b0;
    else if (fbuf_mode_i) bit0 = !fbuf_rdy_i;
    else                  bit0 = (addr_bank_i != bank_q);
  end

  assign status_o = pack_status(ready_q, esusp_q, psusp_q, fail_q, bit0);
  assign view_o   = view_q;

  p_fail_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_stat |=> ((fail_q & $past(fail_q)) == $past(fail_q)));
  p_fail_only_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_q |=> ((fail_q & ~$past(fail_q)) == '0));
  p_fail_beats_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_stat && !ready_q) |=> ((fail_q & $past(fail_i)) == $past(fail_i)));
  p_bit0_legal_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[7] |-> !status_o[0]);
  p_start_refused_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_cmd && any_fail) |=> (cmd_rej_o && !eng_start_o));
  p_start_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_rej_o && eng_start_o));
endmodule

// File: rtl/fsu_read_port.sv
module fsu_read_port
  import fsu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [STAT_W-1:0] status_i,
  input  view_e             view_i,
  input  logic              burst_i,
  input  logic [STAT_W-1:0] array_i,
  output logic [STAT_W-1:0] data_o,
  output logic              proto_err_o
);
  logic              act_q;
  view_e             view_q;
  logic [STAT_W-1:0] snap_q;
  logic              capture;

  assign capture = en_i && !act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q       <= 1'b0;
      view_q      <= VIEW_ARRAY;
      snap_q      <= '0;
      proto_err_o <= 1'b0;
    end else begin
      act_q       <= en_i;
      proto_err_o <= capture && burst_i && (view_i == VIEW_STATUS);
      if (capture) begin
        snap_q <= status_i;
        view_q <= view_i;
      end
    end
  end

  always_comb begin
    if (!act_q)                     data_o = '0;
    else if (view_q == VIEW_STATUS) data_o = snap_q;
    else                            data_o = array_i;
  end

  p_status_held_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && $past(act_q) && view_q == VIEW_STATUS) |-> $stable(data_o));
  p_idle_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_q |-> (data_o == '0));
  p_burst_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_err_o |=> !proto_err_o);
endmodule

// File: rtl/flash_status_unit.sv
module flash_status_unit
  import fsu_pkg::*;
#(
  parameter  int unsigned NUM_BANKS   = 4,
  parameter  int unsigned SYNC_STAGES = 2,
  localparam int unsigned BANK_W      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        cmd_i,
  input  logic              ev_busy_i,
  input  logic              ev_done_i,
  input  logic              ev_esusp_i,
  input  logic              ev_psusp_i,
  input  logic              ev_resume_i,
  input  logic [BANK_W-1:0] ev_bank_i,
  input  logic              fail_erase_i,
  input  logic              fail_prog_i,
  input  logic              fail_vpp_i,
  input  logic              fail_prot_i,
  input  logic              fbuf_mode_i,
  input  logic              fbuf_rdy_i,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              burst_i,
  input  logic [BANK_W-1:0] addr_bank_i,
  input  logic [7:0]        array_data_i,
  output logic [7:0]        data_o,
  output logic              proto_err_o,
  output logic              eng_start_o,
  output logic              cmd_rej_o
);
  logic              ce_s_n, oe_s_n, rd_en;
  logic [STAT_W-1:0] status;
  view_e             view;
  fail_t             fail_in;

  assign fail_in = '{erase: fail_erase_i, prog: fail_prog_i, vpp: fail_vpp_i, prot: fail_prot_i};

  fsu_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_ce (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ce_ni), .q_o(ce_s_n)
  );
  fsu_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_oe (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(oe_ni), .q_o(oe_s_n)
  );

  assign rd_en = !ce_s_n && !oe_s_n;

  fsu_status_core #(.BANK_W(BANK_W)) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_i       (cmd_i),
    .ev_busy_i   (ev_busy_i),
    .ev_done_i   (ev_done_i),
    .ev_esusp_i  (ev_esusp_i),
    .ev_psusp_i  (ev_psusp_i),
    .ev_resume_i (ev_resume_i),
    .ev_bank_i   (ev_bank_i),
    .fail_i      (fail_in),
    .fbuf_mode_i (fbuf_mode_i),
    .fbuf_rdy_i  (fbuf_rdy_i),
    .addr_bank_i (addr_bank_i),
    .status_o    (status),
    .view_o      (view),
    .eng_start_o (eng_start_o),
    .cmd_rej_o   (cmd_rej_o)
  );

  fsu_read_port u_rd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (rd_en),
    .status_i    (status),
    .view_i      (view),
    .burst_i     (burst_i),
    .array_i     (array_data_i),
    .data_o      (data_o),
    .proto_err_o (proto_err_o)
  );
endmodule

// File: tb/sim_flash_status_unit.sv
module sim_flash_status_unit;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned NBANK      = 4;
  localparam int unsigned SYNC       = 2;
  localparam int unsigned BW         = 2;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic [2:0]    cmd = 3'd0;
  logic          ev_busy = 0, ev_done = 0, ev_es = 0, ev_ps = 0, ev_res = 0;
  logic [BW-1:0] ev_bank = '0, addr_bank = '0;
  logic          f_e = 0, f_p = 0, f_v = 0, f_x = 0;
  logic          fb_mode = 0, fb_rdy = 0, ce_n = 1, oe_n = 1, burst = 0;
  logic [7:0]    arr = '0, data;
  logic          perr, estart, rej;

  int n_chk = 0, n_bad = 0;
  logic m_ready = 1, m_es = 0, m_ps = 0, m_view = 0;
  logic [3:0] m_fail = '0;
  logic [BW-1:0] m_bank = '0;
  bit done_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_status_unit #(.NUM_BANKS(NBANK), .SYNC_STAGES(SYNC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd),
    .ev_busy_i(ev_busy), .ev_done_i(ev_done), .ev_esusp_i(ev_es), .ev_psusp_i(ev_ps),
    .ev_resume_i(ev_res), .ev_bank_i(ev_bank),
    .fail_erase_i(f_e), .fail_prog_i(f_p), .fail_vpp_i(f_v), .fail_prot_i(f_x),
    .fbuf_mode_i(fb_mode), .fbuf_rdy_i(fb_rdy), .ce_ni(ce_n), .oe_ni(oe_n),
    .burst_i(burst), .addr_bank_i(addr_bank), .array_data_i(arr),
    .data_o(data), .proto_err_o(perr), .eng_start_o(estart), .cmd_rej_o(rej)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // expected status byte from requirement bit positions (R2..R7)
  function automatic logic [7:0] exp_status(input logic [BW-1:0] ab, input logic fm, input logic fr);
    logic b0;
    if (m_ready)  b0 = 1'b0;
    else if (fm)  b0 = !fr;
    else          b0 = (ab != m_bank);
    return {m_ready, m_es, m_fail[3], m_fail[2], m_fail[1], m_ps, m_fail[0], b0};
  endfunction

  // ev bits: 0 busy,1 done,2 esusp,3 psusp,4 resume; fl: {erase,prog,vpp,prot}
  task automatic cyc(input logic [2:0] c, input logic [4:0] ev, input logic [3:0] fl);
    logic pre_ready;
    logic [3:0] pre_fail;
    cmd = c; {ev_res, ev_ps, ev_es, ev_done, ev_busy} = ev; {f_e, f_p, f_v, f_x} = fl;
    @(posedge clk);
    pre_ready = m_ready; pre_fail = m_fail;
    if (ev[1])      begin m_ready = 1; m_es = 0; m_ps = 0; end
    else if (ev[2]) begin m_ready = 1; m_es = 1; end
    else if (ev[3]) begin m_ready = 1; m_ps = 1; end
    else if (ev[4]) begin m_ready = 0; m_es = 0; m_ps = 0; end
    else if (ev[0]) begin m_ready = 0; m_bank = ev_bank; end
    m_fail = ((c == 3'd2) ? 4'b0 : m_fail) | (pre_ready ? 4'b0 : fl);
    if (c == 3'd1) m_view = 1;
    else if (c == 3'd3) m_view = 0;
    else if (c == 3'd4 && pre_fail == 0) m_view = 1;
    @(negedge clk);
    cmd = 3'd0; {ev_res, ev_ps, ev_es, ev_done, ev_busy} = '0; {f_e, f_p, f_v, f_x} = '0;
    check("R11 start pulse", {7'd0, estart}, {7'd0, (c == 3'd4) && pre_fail == 0});
    check("R11 reject pulse", {7'd0, rej}, {7'd0, (c == 3'd4) && pre_fail != 0});
  endtask

  task automatic rd(input string req, input logic [BW-1:0] ab, input logic b,
                    input logic fm, input logic fr, input logic [4:0] hold_ev, input logic [3:0] hold_fl);
    logic [7:0] exp;
    logic v;
    addr_bank = ab; burst = b; fb_mode = fm; fb_rdy = fr; arr = 8'($urandom);
    v = m_view;
    exp = v ? exp_status(ab, fm, fr) : arr;
    ce_n = 0; oe_n = 0;
    repeat (SYNC + 1) @(posedge clk);
    @(negedge clk);
    check(req, data, exp);
    check("R10 burst flag", {7'd0, perr}, {7'd0, b && v});
    cyc(3'd0, hold_ev, hold_fl);
    arr = 8'($urandom);
    if (!v) exp = arr;
    #1;
    check("R8 held snapshot", data, exp);
    ce_n = 1; oe_n = 1; burst = 0;
    repeat (SYNC + 1) @(posedge clk);
    @(negedge clk);
    check("R9 idle zero", data, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 data idle", data, 8'h00);
    check("R1 outputs low", {5'd0, perr, estart, rej}, 8'h00);
    rd("R1 array view after reset", 2'd0, 0, 0, 0, 5'd0, 4'd0);
    cyc(3'd1, 5'd0, 4'd0);
    rd("R1 reset status", 2'd1, 0, 0, 0, 5'd0, 4'd0);
    cyc(3'd4, 5'd0, 4'd0);
    ev_bank = 2'd2;
    cyc(3'd0, 5'b00001, 4'd0);
    rd("R6 same bank busy", 2'd2, 0, 0, 0, 5'd0, 4'd0);
    rd("R6 other bank busy", 2'd1, 0, 0, 0, 5'd0, 4'd0);
    cyc(3'd0, 5'd0, 4'b0100);
    rd("R4 program flag", 2'd2, 0, 0, 0, 5'b00010, 4'b0001);
    cyc(3'd0, 5'd0, 4'b0010);
    rd("R5 flag ignored while ready", 2'd2, 0, 0, 0, 5'd0, 4'd0);
    cyc(3'd4, 5'd0, 4'd0);
    ev_bank = 2'd3;
    cyc(3'd0, 5'b00001, 4'd0);
    cyc(3'd2, 5'd0, 4'b1000);
    rd("R5 set beats clear", 2'd3, 0, 0, 0, 5'd0, 4'd0);
    cyc(3'd0, 5'b00100, 4'd0);
    rd("R3 erase suspend", 2'd0, 0, 0, 0, 5'd0, 4'd0);
    cyc(3'd0, 5'b10000, 4'd0);
    cyc(3'd0, 5'b01000, 4'd0);
    rd("R3 program suspend", 2'd0, 0, 0, 0, 5'b10000, 4'd0);
    rd("R2 resumed busy", 2'd3, 0, 0, 0, 5'd0, 4'd0);
    rd("R7 buffer ready", 2'd0, 0, 1, 1, 5'd0, 4'd0);
    rd("R7 buffer not ready", 2'd3, 0, 1, 0, 5'd0, 4'd0);
    rd("R10 burst status", 2'd3, 1, 0, 0, 5'd0, 4'd0);
    cyc(3'd2, 5'b00010, 4'd0);
    rd("R4 cleared", 2'd0, 0, 1, 0, 5'd0, 4'd0);
    cyc(3'd3, 5'd0, 4'd0);
    rd("R9 array view", 2'd0, 1, 0, 0, 5'd0, 4'd0);
    cyc(3'd7, 5'd0, 4'd0);
    rd("R11 unused code ignored", 2'd0, 0, 0, 0, 5'd0, 4'd0);
    for (int i = 0; i < 500; i++) begin
      int unsigned r;
      r = $urandom % 16;
      ev_bank = BW'($urandom);
      case (r)
        0, 1:    cyc(3'd0, 5'b00001, 4'd0);
        2:       cyc(3'd0, 5'b00010, 4'd0);
        3:       cyc(3'd0, 5'b00100, 4'd0);
        4:       cyc(3'd0, 5'b01000, 4'd0);
        5:       cyc(3'd0, 5'b10000, 4'd0);
        6, 7:    cyc(3'd0, 5'd0, 4'(1 << ($urandom % 4)));
        8:       cyc(3'd2, 5'd0, ($urandom % 2) ? 4'(1 << ($urandom % 4)) : 4'd0);
        9:       cyc(3'd4, 5'd0, 4'd0);
        10:      cyc(3'd1, 5'd0, 4'd0);
        11:      cyc(3'd3, 5'd0, 4'd0);
        default: rd("R8 random read", BW'($urandom), ($urandom % 4) == 0, ($urandom % 3) == 0,
                    1'($urandom), 5'(1 << ($urandom % 5)), 4'($urandom));
      endcase
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule